// File: doc/BRIEF.md
# Half-Bridge Gate Controller

This block is the clocked decision logic behind a two-transistor half-bridge steered by one command bit. A high command asks for the upper switch, a low command asks for the lower switch. Every change of side leaves both gates off for a fixed number of clock cycles. The block never lets both gate enables be high in the same cycle. The analog parts of the driver (level shifter, regulators, charge pump, comparators) live outside it and reach it only as digital flags: a switch-node-high sense, a supply-good flag and a bootstrap-good flag.

Each gate that is on is watched for a stuck switch node. If the node does not reach the level the active switch should produce within a side-specific window, the block latches a short-circuit fault. The fault turns both gates off and stays set until the enable input goes from low to high. A supply undervoltage also forces both gates off and raises the fault flag, but it clears by itself once the supply is good again. A bootstrap undervoltage only holds the upper gate off and never raises the fault flag. Command, enable and all three flags pass through a two-stage synchronizer before any decision uses them.

Top module: `hb_gate_ctrl`

## Requirements
- R1: When the side changes, the gate being released falls first. The opposite gate rises exactly DEAD_CYC clock edges later, and both gates are low for the cycles in between.
- R2: hsGate and lsGate are never high in the same cycle.
- R3: While the synchronized enable is low, both gates are low whatever the command is. A low enable does not raise faultOut.
- R4: If hsGate is on with the bootstrap good and the node low for HS_TMO consecutive cycles, the fault latches. If lsGate is on with the node high for LS_TMO consecutive cycles, the fault latches. On the latching edge both gates fall and faultOut rises.
- R5: A latched short fault keeps both gates low and faultOut high through command changes and through enable being low. Only a low-to-high transition of the synchronized enable clears it.
- R6: On the edge where the fault clears, the command level picks the side that turns on (command 1: upper, command 0: lower). The dead time must already have elapsed for the gate to turn on at that edge.
- R7: A low supply-good flag raises faultOut two edges after the input falls and forces both gates low one edge after that. When the flag returns, faultOut falls and normal gating resumes with the same latency, without any enable edge.
- R8: While the bootstrap is bad and the node is low, a high command keeps hsGate low. lsGate still follows a low command, and faultOut stays low.
- R9: An upper-side request is granted while the bootstrap is good or the node is high. A request held back by a bad bootstrap is granted three edges after the bootstrap-good input returns.
- R10: During reset both gates and faultOut are low. An input change reaches the gates on the third rising edge after it is applied (two synchronizer stages plus the gate register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmdIn | input | 1 | Side command: 1 upper switch, 0 lower switch |
| enIn | input | 1 | Enable; a rising edge clears a latched short |
| swNodeHi | input | 1 | Switch node sensed high |
| vddGood | input | 1 | Internal supply above its undervoltage threshold |
| bootGood | input | 1 | Bootstrap supply above its undervoltage threshold |
| hsGate | output | 1 | Upper gate enable |
| lsGate | output | 1 | Lower gate enable |
| faultOut | output | 1 | Short latched or supply undervoltage |

## Verification
A dead-time counter that is wrong shows up as a gate rising one cycle early or late after the opposite gate falls. Because every gate edge is checked on its exact cycle, such an error is caught on the first side change. A short timer that is wrong moves the fault edge by a cycle, or makes it trip on a healthy transition, within HS_TMO or LS_TMO cycles of the gate turning on. A fault latch that is wrong either drops the fault on a command change or a low enable, or fails to clear on the enable edge. The bench probes each of these conditions in turn, several cycles apart.

// File: rtl/hb_pkg.sv
package hb_pkg;

  // Bit positions of the synchronized input bundle
  localparam int IX_CMD  = 0;
  localparam int IX_EN   = 1;
  localparam int IX_SW   = 2;
  localparam int IX_VDD  = 3;
  localparam int IX_BOOT = 4;
  localparam int IN_W    = 5;

  // Control to datapath strobes
  typedef struct packed {
    logic hsOn;    // upper gate register is high
    logic lsOn;    // lower gate register is high
    logic armHs;   // upper-side short window running
    logic armLs;   // lower-side short window running
    logic enRise;  // synchronized enable rose this cycle
  } hbStrobe_t;

  // Datapath to control status
  typedef struct packed {
    logic hsOffDone;  // upper gate off long enough
    logic lsOffDone;  // lower gate off long enough
    logic trip;       // short window expired this cycle
    logic faultNext;  // latch value after this edge
    logic faultLatch; // latched short fault
  } hbStatus_t;

  function automatic int cntWidth(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] qOut
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST_VAL;
    else        chain[0] <= dIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RST_VAL;
      else        chain[s] <= chain[s-1];
    end
  end

  assign qOut = chain[STAGES-1];

endmodule

// File: rtl/hb_dpath.sv
module hb_dpath
  import hb_pkg::*;
#(
  parameter int DEAD_CYC = 4,
  parameter int HS_TMO   = 30,
  parameter int LS_TMO   = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  hbStrobe_t  strobe,
  output hbStatus_t  status
);

  localparam int DW     = cntWidth(DEAD_CYC);
  localparam int MAXTMO = (HS_TMO > LS_TMO) ? HS_TMO : LS_TMO;
  localparam int TW     = cntWidth(MAXTMO);
  localparam logic [DW-1:0] DEAD_LIM = DW'(DEAD_CYC - 1);
  localparam logic [TW-1:0] HS_LIM   = TW'(HS_TMO - 1);
  localparam logic [TW-1:0] LS_LIM   = TW'(LS_TMO - 1);

  // ---------------- dead-time counters, one per side ----------------
  // index 1: upper side, index 0: lower side
  logic [1:0]    gateOn;
  logic [1:0]    offDone;
  logic [DW-1:0] offCnt [2];

  assign gateOn = {strobe.hsOn, strobe.lsOn};

  for (genvar g = 0; g < 2; g++) begin : g_side
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            offCnt[g] <= DEAD_LIM;
      else if (gateOn[g])    offCnt[g] <= '0;
      else if (!offDone[g])  offCnt[g] <= offCnt[g] + 1'b1;
    end
    assign offDone[g] = (offCnt[g] == DEAD_LIM);
  end

  // ---------------- short-circuit window timer ----------------
  logic          armed;
  logic [TW-1:0] tmr;
  logic [TW-1:0] tmrLim;
  logic          trip;

  assign armed  = strobe.armHs | strobe.armLs;
  assign tmrLim = strobe.armHs ? HS_LIM : LS_LIM;
  assign trip   = armed && (tmr == tmrLim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmr <= '0;
    else if (!armed) tmr <= '0;
    else if (!trip)  tmr <= tmr + 1'b1;
  end

  // ---------------- fault latch ----------------
  logic faultLatch;
  logic faultNext;

  assign faultNext = trip | (faultLatch & ~strobe.enRise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) faultLatch <= 1'b0;
    else        faultLatch <= faultNext;
  end

  assign status.hsOffDone  = offDone[1];
  assign status.lsOffDone  = offDone[0];
  assign status.trip       = trip;
  assign status.faultNext  = faultNext;
  assign status.faultLatch = faultLatch;

  // ---------------- assertions ----------------
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (faultLatch && !strobe.enRise) |=> faultLatch); // R5

  AST_ARM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.armHs && strobe.armLs)); // R4

  AST_OFF_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe.lsOn) |-> !offDone[0]); // R1

endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
  import hb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmdS,
  input  logic       enS,
  input  logic       swS,
  input  logic       vddS,
  input  logic       bootS,
  input  hbStatus_t  status,
  output hbStrobe_t  strobe,
  output logic       hsGate,
  output logic       lsGate,
  output logic       faultOut
);

  logic enPrev;
  logic enRise;
  logic run;
  logic hsWant;
  logic lsWant;
  logic hsNext;
  logic lsNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enPrev <= 1'b0;
    else        enPrev <= enS;
  end

  assign enRise = enS & ~enPrev;

  // Permission to drive any gate this cycle
  assign run    = enS & vddS & ~status.faultNext;

  // Side requests; upper side needs a charged bootstrap or a high node
  assign hsWant = run & cmdS & (bootS | swS);
  assign lsWant = run & ~cmdS;

  // Turn-on only once the opposite gate has been off for the dead time
  assign hsNext = hsWant & ~lsGate & status.lsOffDone;
  assign lsNext = lsWant & ~hsGate & status.hsOffDone;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsGate <= 1'b0;
      lsGate <= 1'b0;
    end else begin
      hsGate <= hsNext;
      lsGate <= lsNext;
    end
  end

  assign strobe.hsOn   = hsGate;
  assign strobe.lsOn   = lsGate;
  assign strobe.armHs  = hsGate & bootS & ~swS;
  assign strobe.armLs  = lsGate & swS;
  assign strobe.enRise = enRise;

  assign faultOut = status.faultLatch | ~vddS;

  // ---------------- assertions ----------------
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(hsGate && lsGate)); // R2

  AST_HS_DEADTIME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsGate) |-> $past(status.lsOffDone)); // R1

  AST_LS_DEADTIME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lsGate) |-> $past(status.hsOffDone)); // R1

  AST_DISABLED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enS |=> (!hsGate && !lsGate)); // R3

  AST_UV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !vddS |=> (!hsGate && !lsGate)); // R7

  AST_HS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsGate) |-> $past(bootS || swS)); // R9

  AST_TRIP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    status.trip |=> (!hsGate && !lsGate && status.faultLatch)); // R4

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_pkg::*;
#(
  parameter int DEAD_CYC    = 4,
  parameter int HS_TMO      = 30,
  parameter int LS_TMO      = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmdIn,
  input  logic enIn,
  input  logic swNodeHi,
  input  logic vddGood,
  input  logic bootGood,
  output logic hsGate,
  output logic lsGate,
  output logic faultOut
);

  // Supply flags reset as good so reset alone never shows a fault
  localparam logic [IN_W-1:0] SYNC_RST =
    IN_W'((1 << IX_VDD) | (1 << IX_BOOT));

  logic [IN_W-1:0] rawIn;
  logic [IN_W-1:0] syncIn;
  hbStrobe_t       strobe;
  hbStatus_t       status;

  always_comb begin
    rawIn          = '0;
    rawIn[IX_CMD]  = cmdIn;
    rawIn[IX_EN]   = enIn;
    rawIn[IX_SW]   = swNodeHi;
    rawIn[IX_VDD]  = vddGood;
    rawIn[IX_BOOT] = bootGood;
  end

  hb_sync #(
    .W       (IN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SYNC_RST)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .dIn   (rawIn),
    .qOut  (syncIn)
  );

  hb_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmdS     (syncIn[IX_CMD]),
    .enS      (syncIn[IX_EN]),
    .swS      (syncIn[IX_SW]),
    .vddS     (syncIn[IX_VDD]),
    .bootS    (syncIn[IX_BOOT]),
    .status   (status),
    .strobe   (strobe),
    .hsGate   (hsGate),
    .lsGate   (lsGate),
    .faultOut (faultOut)
  );

  hb_dpath #(
    .DEAD_CYC (DEAD_CYC),
    .HS_TMO   (HS_TMO),
    .LS_TMO   (LS_TMO)
  ) u_dpath (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .status (status)
  );

endmodule

// File: tb/sim_hb_gate_ctrl.sv
module sim_hb_gate_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DEAD       = 4;
  localparam int HS_T       = 30;
  localparam int LS_T       = 20;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0;
  logic rst_n;
  logic cmdIn, enIn, swNodeHi, vddGood, bootGood;
  logic hsGate, lsGate, faultOut;

  typedef struct {
    logic  hs;
    logic  ls;
    logic  flt;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hb_gate_ctrl #(
    .DEAD_CYC (DEAD),
    .HS_TMO   (HS_T),
    .LS_TMO   (LS_T)
  ) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmdIn    (cmdIn),
    .enIn     (enIn),
    .swNodeHi (swNodeHi),
    .vddGood  (vddGood),
    .bootGood (bootGood),
    .hsGate   (hsGate),
    .lsGate   (lsGate),
    .faultOut (faultOut)
  );

  // ---------------- driver side ----------------
  task automatic drive(input logic c, input logic e, input logic s,
                       input logic v, input logic b);
    @(negedge clk);
    cmdIn = c; enIn = e; swNodeHi = s; vddGood = v; bootGood = b;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic pushExp(input logic hs, input logic ls, input logic flt,
                         input string tag);
    expItem_t it;
    #1;
    it.hs = hs; it.ls = ls; it.flt = flt; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  // ---------------- monitor side ----------------
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        nChecks++;
        if (hsGate !== it.hs || lsGate !== it.ls || faultOut !== it.flt) begin
          nFails++;
          $display("FAIL %s: got hs=%0b ls=%0b fault=%0b, expected hs=%0b ls=%0b fault=%0b",
                   it.tag, hsGate, lsGate, faultOut, it.hs, it.ls, it.flt);
        end
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got running, expected finished");
      report();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 1'b0;
    cmdIn = 1'b0; enIn = 1'b0; swNodeHi = 1'b0; vddGood = 1'b1; bootGood = 1'b1;
    edges(3);
    pushExp(0, 0, 0, "R10 reset state");
    @(negedge clk);
    rst_n = 1'b1;

    // R3: disabled, command high
    drive(1, 0, 0, 1, 1); edges(5);
    pushExp(0, 0, 0, "R3 disabled with command high");

    // R10: enable with command low, latency of three edges
    drive(0, 1, 0, 1, 1); edges(2);
    pushExp(0, 0, 0, "R10 not yet after two edges");
    edges(1);
    pushExp(0, 1, 0, "R10 lower gate on third edge");

    // R1: lower to upper change
    drive(1, 1, 0, 1, 1); edges(3);
    pushExp(0, 0, 0, "R1 lower gate released first");
    edges(DEAD - 1);
    pushExp(0, 0, 0, "R1 both off during dead time");
    edges(1);
    pushExp(1, 0, 0, "R1 upper gate after dead time");
    drive(1, 1, 1, 1, 1);

    // R1/R2: upper to lower change
    drive(0, 1, 1, 1, 1); edges(3);
    pushExp(0, 0, 0, "R1 upper gate released first");
    edges(DEAD - 1);
    pushExp(0, 0, 0, "R2 both off before lower turn-on");
    edges(1);
    pushExp(0, 1, 0, "R1 lower gate after dead time");
    drive(0, 1, 0, 1, 1); edges(4);
    pushExp(0, 1, 0, "R4 healthy transition does not trip");

    // R4: upper side short, node stuck low
    drive(1, 1, 0, 1, 1); edges(3 + DEAD);
    pushExp(1, 0, 0, "R4 upper gate on with node low");
    edges(HS_T - 1);
    pushExp(1, 0, 0, "R4 upper window not yet expired");
    edges(1);
    pushExp(0, 0, 1, "R4 upper short latched");

    // R5: latch holds
    drive(0, 1, 0, 1, 1); edges(6);
    pushExp(0, 0, 1, "R5 command change keeps fault");
    drive(0, 0, 0, 1, 1); edges(4);
    pushExp(0, 0, 1, "R5 enable low keeps fault");
    drive(0, 1, 0, 1, 1); edges(2);
    pushExp(0, 0, 1, "R5 held until enable edge is synchronized");
    edges(1);
    pushExp(0, 1, 0, "R6 command low restarts on lower gate");

    // R4: lower side short, node stuck high
    drive(0, 1, 1, 1, 1); edges(1 + LS_T);
    pushExp(0, 1, 0, "R4 lower window not yet expired");
    edges(1);
    pushExp(0, 0, 1, "R4 lower short latched");

    // R6: restart with command high
    drive(1, 0, 1, 1, 1); edges(4);
    pushExp(0, 0, 1, "R5 fault kept while disabled");
    drive(1, 1, 1, 1, 1); edges(3);
    pushExp(1, 0, 0, "R6 command high restarts on upper gate");

    // R9 / R8: bootstrap undervoltage
    drive(1, 1, 1, 1, 0); edges(4);
    pushExp(1, 0, 0, "R9 high node keeps upper gate with bootstrap bad");
    drive(1, 1, 0, 1, 0); edges(3);
    pushExp(0, 0, 0, "R8 upper gate off, no fault, bootstrap bad");
    edges(6);
    drive(0, 1, 0, 1, 0); edges(3);
    pushExp(0, 1, 0, "R8 lower gate works with bootstrap bad");
    drive(1, 1, 0, 1, 0); edges(3 + DEAD + 3);
    pushExp(0, 0, 0, "R9 upper request pending");
    drive(1, 1, 0, 1, 1); edges(3);
    pushExp(1, 0, 0, "R9 pending request granted on recovery");
    drive(1, 1, 1, 1, 1);

    // R7: supply undervoltage
    drive(1, 1, 1, 0, 1); edges(2);
    pushExp(1, 0, 1, "R7 fault flag on supply loss");
    edges(1);
    pushExp(0, 0, 1, "R7 gates off on supply loss");
    drive(1, 1, 1, 1, 1); edges(2);
    pushExp(0, 0, 0, "R7 fault flag clears by itself");
    edges(1);
    pushExp(1, 0, 0, "R7 operation resumes without enable edge");

    // R3: enable low turns everything off
    drive(1, 0, 1, 1, 1); edges(3);
    pushExp(0, 0, 0, "R3 enable low turns gates off");

    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    report();
  end

endmodule